// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block is a purely combinational post-processor that sits beside the adder of a 16-bit accumulator datapath. It takes a byte result that has already been produced, together with the incoming auxiliary-carry and carry flags, and rewrites it for one of eight operations:

- correction of unpacked decimal digits after an add or a subtract;
- correction of packed two-digit BCD after an add or a subtract;
- splitting a byte into two decimal digits, or merging two digits back into a binary byte;
- widening a signed byte into a word, or a signed word into a double word.

Operands arrive already fetched. The block never computes the add or subtract itself: it only adjusts what it is given.

The accumulator is presented as a low byte and a high byte, which together form the word. An extension word input is also present, and it receives the sign spread when a word is widened. Every output that a selected operation does not rewrite carries its input through unchanged. The six output flags follow fixed rules for each operation, so the surrounding flag register can load them as they are.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With op_sel=0 (unpacked add correction), if the low nibble of acc_lo_in exceeds 9 or aux_in is 1, then acc_lo_out=(acc_lo_in+0x06)&0x0F, acc_hi_out=acc_hi_in+1, and aux_out=carry_out=1. Otherwise acc_lo_out=acc_lo_in&0x0F, acc_hi_out=acc_hi_in, and aux_out=carry_out=0. Example: 0x66 gives 0x06 with both flags clear.
- R2: With op_sel=1 (unpacked subtract correction), the condition is the same as in R1. When it holds, acc_lo_out=(acc_lo_in-0x06)&0x0F, acc_hi_out=acc_hi_in-1, and aux_out=carry_out=1. Otherwise acc_lo_out=acc_lo_in&0x0F, acc_hi_out is unchanged, and both flags are 0.
- R3: With op_sel=2 (packed add correction), 0x06 is added when the low nibble exceeds 9 or aux_in=1, and then aux_out=1. Separately, 0x60 is added when the original acc_lo_in exceeds 0x99 or carry_in=1, and then carry_out=1. Each flag is 0 when its condition fails.
- R4: With op_sel=3 (packed subtract correction), the same conditions as in R3 apply, but each correction is subtracted instead of added.
- R5: With op_sel=4 (digit split), acc_hi_out=acc_lo_in/10 and acc_lo_out=acc_lo_in mod 10.
- R6: With op_sel=5 (digit merge), acc_lo_out=(acc_hi_in*10+acc_lo_in) mod 256 and acc_hi_out=0.
- R7: With op_sel=6 (byte widen), every bit of acc_hi_out equals bit 7 of acc_lo_in. acc_lo_out and ext_out are unchanged, and aux_out and carry_out pass through aux_in and carry_in.
- R8: With op_sel=7 (word widen), every bit of ext_out equals bit 7 of acc_hi_in. Both accumulator bytes pass through, and aux_out and carry_out pass through aux_in and carry_in. Example: a low byte of 0xFA widened to 0xFFFA gives an extension of 0xFFFF.
- R9: For op_sel 2 to 5, sign_out is bit 7 of acc_lo_out, zero_out is 1 exactly when acc_lo_out is 0, parity_out is 1 when acc_lo_out has an even number of ones, and ovf_out=0. For op_sel 4 and 5, aux_out and carry_out are 0.
- R10: Outputs that an operation does not rewrite pass through. ext_out equals ext_in for every op_sel except 7, and acc_hi_out equals acc_hi_in for op_sel 2 and 3.
- R11: div_err is 0 for every input.
- R12: For op_sel 0, 1, 6 and 7, sign_out, zero_out, parity_out and ovf_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation select, encoded 0 to 7 as listed in the requirements |
| acc_lo_in | input | 8 | Accumulator low byte to adjust |
| acc_hi_in | input | 8 | Accumulator high byte |
| ext_in | input | 16 | Extension word, passed through unless op_sel=7 |
| aux_in | input | 1 | Incoming auxiliary (nibble) carry flag |
| carry_in | input | 1 | Incoming carry flag |
| acc_lo_out | output | 8 | Adjusted low byte |
| acc_hi_out | output | 8 | Adjusted high byte |
| ext_out | output | 16 | Adjusted extension word |
| aux_out | output | 1 | New auxiliary carry flag |
| carry_out | output | 1 | New carry flag |
| sign_out | output | 1 | New sign flag |
| zero_out | output | 1 | New zero flag |
| parity_out | output | 1 | New even-parity flag |
| ovf_out | output | 1 | New overflow flag, always 0 |
| div_err | output | 1 | Divide-error strobe for the split operation, always 0 |

## Verification
Every operation is swept over all 256 low-byte values. The high byte, the extension word and the two incoming flags vary with each value, so that nibble-forced corrections can be told apart from flag-forced corrections.

Directed cases cover the following:
- the unpacked results, including the borrow that wraps the high byte from 0x00 to 0xFF;
- the packed-BCD edge values 0x99 and 0x9A, which separate the "greater than 0x99" test from a "greater than or equal" test;
- a zero byte with the carry flag set;
- a merge whose product overflows a byte;
- both signs for each widening operation.

Pass-through values such as 0xBEEF in the extension word show up any output that is rewritten when it should not be.

// File: rtl/adj_pkg.sv
package adj_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int RADIX  = 10;

    localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(RADIX - 1);
    localparam logic [BYTE_W-1:0] LO_FIX   = BYTE_W'(16 - RADIX);
    localparam logic [BYTE_W-1:0] HI_FIX   = LO_FIX << NIB_W;
    localparam logic [BYTE_W-1:0] BCD_MAX  = {NIB_MAX, NIB_MAX};
    localparam logic [BYTE_W-1:0] LO_MASK  = {{NIB_W{1'b0}}, {NIB_W{1'b1}}};

    typedef enum logic [2:0] {
        OP_ASC_ADD = 3'd0,
        OP_ASC_SUB = 3'd1,
        OP_BCD_ADD = 3'd2,
        OP_BCD_SUB = 3'd3,
        OP_SPLIT   = 3'd4,
        OP_MERGE   = 3'd5,
        OP_EXT_B   = 3'd6,
        OP_EXT_W   = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [WORD_W-1:0] ext;
        logic              aux;
        logic              carry;
        logic              sign;
        logic              zero;
        logic              parity;
        logic              ovf;
    } adj_res_t;

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic nib_over(input logic [BYTE_W-1:0] v, input logic aux);
        return (v[NIB_W-1:0] > NIB_MAX) || aux;
    endfunction
endpackage

// File: rtl/unpacked_adjust.sv
module unpacked_adjust
    import adj_pkg::*;
(
    input  logic              is_sub,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic              aux_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out,
    output logic              fix_out
);
    logic              fix;
    logic [BYTE_W-1:0] stepped;

    always_comb begin
        fix     = nib_over(lo_in, aux_in);
        stepped = lo_in;
        hi_out  = hi_in;
        if (fix) begin
            if (is_sub) begin
                stepped = lo_in - LO_FIX;
                hi_out  = hi_in - BYTE_W'(1);
            end else begin
                stepped = lo_in + LO_FIX;
                hi_out  = hi_in + BYTE_W'(1);
            end
        end
        lo_out  = stepped & LO_MASK;
        fix_out = fix;
    end
endmodule

// File: rtl/packed_adjust.sv
module packed_adjust
    import adj_pkg::*;
(
    input  logic              is_sub,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic              aux_in,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic              aux_out,
    output logic              carry_out
);
    logic              lo_fix;
    logic              hi_fix;
    logic [BYTE_W-1:0] step_lo;

    always_comb begin
        lo_fix  = nib_over(lo_in, aux_in);
        hi_fix  = (lo_in > BCD_MAX) || carry_in;
        step_lo = lo_in;
        if (lo_fix) begin
            step_lo = is_sub ? (lo_in - LO_FIX) : (lo_in + LO_FIX);
        end
        lo_out = step_lo;
        if (hi_fix) begin
            lo_out = is_sub ? (step_lo - HI_FIX) : (step_lo + HI_FIX);
        end
        aux_out   = lo_fix;
        carry_out = hi_fix;
    end
endmodule

// File: rtl/radix_adjust.sv
module radix_adjust
    import adj_pkg::*;
#(
    parameter int BASE = RADIX
) (
    input  logic              is_split,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);
    localparam logic [BYTE_W-1:0] BASE_B = BYTE_W'(BASE);
    localparam logic [WORD_W-1:0] BASE_W = WORD_W'(BASE);

    logic [WORD_W-1:0] merged;

    always_comb begin
        merged = {{BYTE_W{1'b0}}, hi_in} * BASE_W + {{BYTE_W{1'b0}}, lo_in};
        if (is_split) begin
            hi_out = lo_in / BASE_B;
            lo_out = lo_in % BASE_B;
        end else begin
            lo_out = merged[BYTE_W-1:0];
            hi_out = '0;
        end
    end
endmodule

// File: rtl/sign_extend.sv
module sign_extend
    import adj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] byte_ext,
    output logic [WORD_W-1:0] word_ext
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_byte
        assign byte_ext[i] = lo_in[BYTE_W-1];
    end
    for (genvar j = 0; j < WORD_W; j++) begin : g_word
        assign word_ext[j] = hi_in[BYTE_W-1];
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import adj_pkg::*;
(
    input  logic [2:0]        op_sel,
    input  logic [BYTE_W-1:0] acc_lo_in,
    input  logic [BYTE_W-1:0] acc_hi_in,
    input  logic [WORD_W-1:0] ext_in,
    input  logic              aux_in,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] acc_lo_out,
    output logic [BYTE_W-1:0] acc_hi_out,
    output logic [WORD_W-1:0] ext_out,
    output logic              aux_out,
    output logic              carry_out,
    output logic              sign_out,
    output logic              zero_out,
    output logic              parity_out,
    output logic              ovf_out,
    output logic              div_err
);
    adj_op_e op;
    assign op = adj_op_e'(op_sel);

    logic [BYTE_W-1:0] up_lo, up_hi;
    logic              up_fix;
    logic [BYTE_W-1:0] pk_lo;
    logic              pk_aux, pk_carry;
    logic [BYTE_W-1:0] rx_lo, rx_hi;
    logic [BYTE_W-1:0] sx_byte;
    logic [WORD_W-1:0] sx_word;

    unpacked_adjust u_unpacked (
        .is_sub  (op == OP_ASC_SUB),
        .lo_in   (acc_lo_in),
        .hi_in   (acc_hi_in),
        .aux_in  (aux_in),
        .lo_out  (up_lo),
        .hi_out  (up_hi),
        .fix_out (up_fix)
    );

    packed_adjust u_packed (
        .is_sub    (op == OP_BCD_SUB),
        .lo_in     (acc_lo_in),
        .aux_in    (aux_in),
        .carry_in  (carry_in),
        .lo_out    (pk_lo),
        .aux_out   (pk_aux),
        .carry_out (pk_carry)
    );

    radix_adjust #(.BASE(RADIX)) u_radix (
        .is_split (op == OP_SPLIT),
        .lo_in    (acc_lo_in),
        .hi_in    (acc_hi_in),
        .lo_out   (rx_lo),
        .hi_out   (rx_hi)
    );

    sign_extend u_sext (
        .lo_in    (acc_lo_in),
        .hi_in    (acc_hi_in),
        .byte_ext (sx_byte),
        .word_ext (sx_word)
    );

    adj_res_t res;
    logic     arith_flags;

    always_comb begin
        res.lo     = acc_lo_in;
        res.hi     = acc_hi_in;
        res.ext    = ext_in;
        res.aux    = aux_in;
        res.carry  = carry_in;
        res.sign   = 1'b0;
        res.zero   = 1'b0;
        res.parity = 1'b0;
        res.ovf    = 1'b0;
        arith_flags = 1'b0;
        unique case (op)
            OP_ASC_ADD, OP_ASC_SUB: begin
                res.lo    = up_lo;
                res.hi    = up_hi;
                res.aux   = up_fix;
                res.carry = up_fix;
            end
            OP_BCD_ADD, OP_BCD_SUB: begin
                res.lo      = pk_lo;
                res.aux     = pk_aux;
                res.carry   = pk_carry;
                arith_flags = 1'b1;
            end
            OP_SPLIT, OP_MERGE: begin
                res.lo      = rx_lo;
                res.hi      = rx_hi;
                res.aux     = 1'b0;
                res.carry   = 1'b0;
                arith_flags = 1'b1;
            end
            OP_EXT_B: res.hi  = sx_byte;
            OP_EXT_W: res.ext = sx_word;
            default: ;
        endcase
        if (arith_flags) begin
            res.sign   = res.lo[BYTE_W-1];
            res.zero   = (res.lo == '0);
            res.parity = even_parity(res.lo);
        end
    end

    assign acc_lo_out = res.lo;
    assign acc_hi_out = res.hi;
    assign ext_out    = res.ext;
    assign aux_out    = res.aux;
    assign carry_out  = res.carry;
    assign sign_out   = res.sign;
    assign zero_out   = res.zero;
    assign parity_out = res.parity;
    assign ovf_out    = res.ovf;
    assign div_err    = 1'b0;

    always_comb begin
        if (!$isunknown({op_sel, acc_lo_in, acc_hi_in, ext_in, aux_in, carry_in})) begin
            if (op == OP_ASC_ADD) begin
                AST_ASC_ADD_STEP: assert (acc_lo_out[BYTE_W-1:NIB_W] == '0 && aux_out == carry_out
                    && acc_hi_out == acc_hi_in + {{(BYTE_W-1){1'b0}}, carry_out})
                    else $error("unpacked add step"); // R1
            end
            if (op == OP_ASC_SUB) begin
                AST_ASC_SUB_STEP: assert (acc_lo_out[BYTE_W-1:NIB_W] == '0 && aux_out == carry_out
                    && acc_hi_out == acc_hi_in - {{(BYTE_W-1){1'b0}}, carry_out})
                    else $error("unpacked sub step"); // R2
            end
            if (op == OP_BCD_ADD && carry_in) begin
                AST_BCD_ADD_CARRY: assert (carry_out) else $error("packed add carry"); // R3
            end
            if (op == OP_BCD_SUB && carry_in) begin
                AST_BCD_SUB_CARRY: assert (carry_out) else $error("packed sub carry"); // R4
            end
            if (op == OP_SPLIT) begin
                AST_SPLIT_RECOMBINE: assert (acc_lo_out < BYTE_W'(RADIX)
                    && ({{BYTE_W{1'b0}}, acc_hi_out} * WORD_W'(RADIX) + {{BYTE_W{1'b0}}, acc_lo_out})
                       == {{BYTE_W{1'b0}}, acc_lo_in})
                    else $error("split does not recombine"); // R5
            end
            if (op == OP_MERGE) begin
                AST_MERGE_HI_CLEAR: assert (acc_hi_out == '0) else $error("merge high byte"); // R6
            end
            if (op == OP_EXT_B) begin
                AST_EXT_B_FILL: assert ((acc_hi_out == '0 || acc_hi_out == '1) && acc_lo_out == acc_lo_in)
                    else $error("byte widen"); // R7
            end
            if (op == OP_EXT_W) begin
                AST_EXT_W_FILL: assert ((ext_out == '0 || ext_out == '1) && ext_out[0] == acc_hi_in[BYTE_W-1])
                    else $error("word widen"); // R8
            end
            if (zero_out) begin
                AST_ZERO_NOT_NEG: assert (!sign_out && parity_out) else $error("zero flag mix"); // R9
            end
            if (op != OP_EXT_W) begin
                AST_EXT_PASS: assert (ext_out == ext_in) else $error("extension rewritten"); // R10
            end
            AST_NO_DIV_ERR: assert (!div_err && !ovf_out) else $error("div error raised"); // R11
            if (op == OP_ASC_ADD || op == OP_ASC_SUB || op == OP_EXT_B || op == OP_EXT_W) begin
                AST_UNDEF_FLAGS_LOW: assert (!sign_out && !zero_out && !parity_out)
                    else $error("undefined flags driven"); // R12
            end
        end
    end
endmodule

// File: tb/bcd_adjust_unit_tb.sv
`timescale 1ns/1ps
module bcd_adjust_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [2:0]  op_sel = '0;
    logic [7:0]  acc_lo_in = '0, acc_hi_in = '0;
    logic [15:0] ext_in = '0;
    logic        aux_in = 1'b0, carry_in = 1'b0;
    logic [7:0]  acc_lo_out, acc_hi_out;
    logic [15:0] ext_out;
    logic        aux_out, carry_out, sign_out, zero_out, parity_out, ovf_out, div_err;

    bcd_adjust_unit u_dut (
        .op_sel(op_sel), .acc_lo_in(acc_lo_in), .acc_hi_in(acc_hi_in), .ext_in(ext_in),
        .aux_in(aux_in), .carry_in(carry_in),
        .acc_lo_out(acc_lo_out), .acc_hi_out(acc_hi_out), .ext_out(ext_out),
        .aux_out(aux_out), .carry_out(carry_out), .sign_out(sign_out), .zero_out(zero_out),
        .parity_out(parity_out), .ovf_out(ovf_out), .div_err(div_err)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [38:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [38:0] pk(input logic [7:0] l, input logic [7:0] h, input logic [15:0] e,
                                       input logic a, input logic c, input logic s, input logic z,
                                       input logic p, input logic o);
        return {l, h, e, a, c, s, z, p, o, 1'b0};
    endfunction

    function automatic logic [38:0] model(input logic [2:0] op, input logic [7:0] l, input logic [7:0] h,
                                          input logic [15:0] e, input logic ai, input logic ci);
        logic [7:0]  lo, hi, t;
        logic [15:0] ex;
        logic        a, c, s, z, p;
        logic [31:0] prod;
        lo = l; hi = h; ex = e; a = ai; c = ci; s = 0; z = 0; p = 0;
        case (op)
            3'd0: if (l[3:0] > 4'd9 || ai) begin lo = (l + 8'h06) & 8'h0F; hi = h + 8'd1; a = 1; c = 1; end
                  else begin lo = l & 8'h0F; a = 0; c = 0; end
            3'd1: if (l[3:0] > 4'd9 || ai) begin lo = (l - 8'h06) & 8'h0F; hi = h - 8'd1; a = 1; c = 1; end
                  else begin lo = l & 8'h0F; a = 0; c = 0; end
            3'd2, 3'd3: begin
                t = l; a = 0; c = 0;
                if (l[3:0] > 4'd9 || ai) begin t = (op == 3'd2) ? t + 8'h06 : t - 8'h06; a = 1; end
                if (l > 8'h99 || ci) begin t = (op == 3'd2) ? t + 8'h60 : t - 8'h60; c = 1; end
                lo = t;
            end
            3'd4: begin hi = l / 8'd10; lo = l % 8'd10; a = 0; c = 0; end
            3'd5: begin prod = 32'(h) * 32'd10 + 32'(l); lo = prod[7:0]; hi = 8'h00; a = 0; c = 0; end
            3'd6: hi = l[7] ? 8'hFF : 8'h00;
            default: ex = h[7] ? 16'hFFFF : 16'h0000;
        endcase
        if (op >= 3'd2 && op <= 3'd5) begin s = lo[7]; z = (lo == 8'h00); p = ~^lo; end
        return pk(lo, hi, ex, a, c, s, z, p, 1'b0);
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic put(input logic [2:0] op, input logic [7:0] l, input logic [7:0] h, input logic [15:0] e,
                       input logic a, input logic c, input logic [38:0] exp, input string tag);
        @(posedge clk);
        #1;
        op_sel = op; acc_lo_in = l; acc_hi_in = h; ext_in = e; aux_in = a; carry_in = c;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [38:0] e, act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {acc_lo_out, acc_hi_out, ext_out, aux_out, carry_out, sign_out, zero_out,
                   parity_out, ovf_out, div_err};
            checks++;
            if (act !== e) begin
                failures++;
                $display("FAIL %s op=%0d lo=%h hi=%h actual=%h expected=%h", t, op_sel, acc_lo_in,
                         acc_hi_in, act, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        put(3'd0, 8'h00, 8'h00, 16'h0000, 0, 0, pk(8'h00, 8'h00, 16'h0000, 0, 0, 0, 0, 0, 0), "R1 idle");
        put(3'd0, 8'h66, 8'h00, 16'h0000, 0, 0, pk(8'h06, 8'h00, 16'h0000, 0, 0, 0, 0, 0, 0), "R1");
        put(3'd0, 8'h6B, 8'h00, 16'h0000, 0, 0, pk(8'h01, 8'h01, 16'h0000, 1, 1, 0, 0, 0, 0), "R1");
        put(3'd0, 8'h05, 8'h03, 16'h0000, 1, 0, pk(8'h0B, 8'h04, 16'h0000, 1, 1, 0, 0, 0, 0), "R1");
        put(3'd1, 8'h2F, 8'h05, 16'h0000, 0, 0, pk(8'h09, 8'h04, 16'h0000, 1, 1, 0, 0, 0, 0), "R2");
        put(3'd1, 8'h03, 8'h00, 16'h0000, 1, 0, pk(8'h0D, 8'hFF, 16'h0000, 1, 1, 0, 0, 0, 0), "R2");
        put(3'd2, 8'h9A, 8'h12, 16'h0000, 0, 0, pk(8'h00, 8'h12, 16'h0000, 1, 1, 0, 1, 1, 0), "R3");
        put(3'd2, 8'h47, 8'h00, 16'h0000, 0, 0, pk(8'h47, 8'h00, 16'h0000, 0, 0, 0, 0, 1, 0), "R3");
        put(3'd3, 8'h00, 8'h00, 16'h0000, 0, 1, pk(8'hA0, 8'h00, 16'h0000, 0, 1, 1, 0, 1, 0), "R4");
        put(3'd3, 8'h4C, 8'h00, 16'h0000, 0, 0, pk(8'h46, 8'h00, 16'h0000, 1, 0, 0, 0, 0, 0), "R4");
        put(3'd4, 8'h63, 8'hAB, 16'h0000, 1, 1, pk(8'h09, 8'h09, 16'h0000, 0, 0, 0, 0, 1, 0), "R5");
        put(3'd4, 8'h00, 8'h00, 16'h0000, 0, 0, pk(8'h00, 8'h00, 16'h0000, 0, 0, 0, 1, 1, 0), "R5");
        put(3'd5, 8'h05, 8'h07, 16'h0000, 0, 0, pk(8'h4B, 8'h00, 16'h0000, 0, 0, 0, 0, 1, 0), "R6");
        put(3'd5, 8'h05, 8'h1A, 16'h0000, 0, 0, pk(8'h09, 8'h00, 16'h0000, 0, 0, 0, 0, 1, 0), "R6");
        put(3'd6, 8'hFA, 8'h00, 16'h1234, 1, 0, pk(8'hFA, 8'hFF, 16'h1234, 1, 0, 0, 0, 0, 0), "R7");
        put(3'd6, 8'h7F, 8'hAA, 16'h0000, 0, 1, pk(8'h7F, 8'h00, 16'h0000, 0, 1, 0, 0, 0, 0), "R7");
        put(3'd7, 8'hFA, 8'hFF, 16'h0000, 0, 0, pk(8'hFA, 8'hFF, 16'hFFFF, 0, 0, 0, 0, 0, 0), "R8");
        put(3'd7, 8'hFF, 8'h7F, 16'hABCD, 0, 0, pk(8'hFF, 8'h7F, 16'h0000, 0, 0, 0, 0, 0, 0), "R8");
        put(3'd2, 8'h99, 8'h00, 16'h0000, 0, 0, pk(8'h99, 8'h00, 16'h0000, 0, 0, 1, 0, 1, 0), "R9");
        put(3'd3, 8'h55, 8'hC3, 16'hBEEF, 0, 0, pk(8'h55, 8'hC3, 16'hBEEF, 0, 0, 0, 0, 1, 0), "R10");
        put(3'd4, 8'hFF, 8'h00, 16'h0000, 0, 0, pk(8'h05, 8'h19, 16'h0000, 0, 0, 0, 0, 1, 0), "R11");
        put(3'd1, 8'hF9, 8'h10, 16'h0000, 0, 0, pk(8'h09, 8'h10, 16'h0000, 0, 0, 0, 0, 0, 0), "R12");
        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0]  l, h;
                logic [15:0] e;
                logic        a, c;
                l = 8'(v); h = l ^ 8'h5A; e = {l, ~l}; a = (v % 3 == 0); c = (v % 5 == 0);
                put(3'(op), l, h, e, a, c, model(3'(op), l, h, e, a, c), op_tag(3'(op)));
            end
        end
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule